// File: doc/BRIEF.md
# Timer Interrupt Vector Generator

This block gathers the event flags of a timer with a dedicated channel 0, up to six further capture/compare channels and a counter overflow event. From them it drives two interrupt request lines. Channel 0 owns the first line outright, and its flag clears when the interrupt controller acknowledges it. Every other channel and the overflow event share the second line.

A software handler on the shared line reads a vector register to learn which source needs service. The register holds the highest-priority source that is both pending and enabled, as an even code, or zero when nothing qualifies. That read also clears the flag of the reported source, so the handler needs no separate clear. Any source still pending keeps the shared line asserted. Each flag is set by a one-cycle pulse from the timer core and is gated by its own enable.

The number of shared channels is a parameter: 2, 4 or 6 for timers with three, five or seven capture/compare channels.

Top module: `timer_irq_vector`

## Requirements
- R1: `ch0_irq` is high exactly when the channel 0 flag is set and `ch0_en` is high. No shared source affects it, and a channel 0 event does not change `shr_irq` or `vec_code`.
- R2: An `ch0_ack` cycle clears the channel 0 flag, so each channel 0 event requests service once. If `ch0_set` arrives in the same cycle as the acknowledge, the flag stays set.
- R3: `shr_irq` is high exactly when at least one shared source (channel 1..N or overflow) has its flag set and its enable high.
- R4: `vec_code` is 0 when no shared source is both pending and enabled.
- R5: Shared channel k (k = 1..N, bit k-1 of `shr_set`/`shr_en`) is reported as code 2·k. Overflow is reported as code 14 for every value of N. Codes are always even.
- R6: When several shared sources qualify, `vec_code` reports the lowest-numbered channel. Overflow has the lowest priority.
- R7: A cycle with `vec_rd` high clears only the flag of the source named by `vec_code` in that cycle. Other pending flags keep `shr_irq` asserted. A flag that is never read stays set and keeps requesting.
- R8: A flag is set by its pulse even while its enable is low. It does not reach `shr_irq` or `vec_code` until the enable goes high, and it is then reported.
- R9: A set pulse that arrives in the same cycle as a vector-read clear of the same flag wins, and the flag stays set.
- R10: A synchronous active-high `rst` clears all flags. After the reset edge, `ch0_irq`, `shr_irq` and `vec_code` are all 0.
- R11: `vec_code` is registered. After each clock edge it reflects the flags as updated by that edge and the enables sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch0_set | input | 1 | Channel 0 event pulse |
| ch0_en | input | 1 | Channel 0 interrupt enable |
| ch0_ack | input | 1 | Channel 0 interrupt acknowledge |
| shr_set | input | NUM_SHARED | Event pulses, channel k on bit k-1 |
| shr_en | input | NUM_SHARED | Enables, channel k on bit k-1 |
| ovf_set | input | 1 | Counter overflow event pulse |
| ovf_en | input | 1 | Overflow interrupt enable |
| vec_rd | input | 1 | Vector register read strobe |
| ch0_irq | output | 1 | Channel 0 interrupt request |
| shr_irq | output | 1 | Shared interrupt request |
| vec_code | output | 4 | Highest-priority pending shared source code |

## Verification
Assertions check on every cycle that the vector code is even and belongs to the legal set. They also check, for each flag, the local update rule: a set pulse always leaves the flag high, a clear without a set leaves it low, and with neither the flag holds. They further check that an acknowledge clears the channel 0 request and that reset empties every output. Priority order among several pending sources, the way enables hide and later reveal latched flags, and a handler draining several sources by repeated reads depend on sequences of stimulus. The bench's directed scenarios show these, along with a long random run compared cycle by cycle against a behavioural model.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    localparam int          CODE_W     = 4;
    localparam int          MAX_SHARED = 6;
    localparam logic [3:0]  CODE_NONE  = 4'd0;
    localparam logic [3:0]  CODE_OVF   = 4'd14;

    // Result of the priority search over shared sources.
    typedef struct packed {
        logic              hit;
        logic [CODE_W-1:0] code;
    } vec_sel_t;

    // Code for shared source index idx out of nsrc sources.
    // The last index is always the overflow source.
    function automatic logic [CODE_W-1:0] src_code(input int idx, input int nsrc);
        if (idx == nsrc - 1)
            return CODE_OVF;
        return CODE_W'(2 * (idx + 1));
    endfunction

endpackage

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_q,
    output logic flag_d,
    output logic pend_o,
    output logic pend_d
);
    // A set pulse always beats a clear in the same cycle.
    always_comb begin
        flag_d = set_i | (flag_q & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else
            flag_q <= flag_d;
    end

    assign pend_o = flag_q & en_i;
    assign pend_d = flag_d & en_i;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q)
        else $error("flag lost a set pulse");

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_q)
        else $error("flag not cleared");

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !set_i) |=> $stable(flag_q))
        else $error("flag changed without cause");

endmodule

// File: rtl/tmr_prio_enc.sv
module tmr_prio_enc
    import tmr_irq_pkg::*;
#(
    parameter int NSRC = 5
) (
    input  logic [NSRC-1:0] pend_i,
    output vec_sel_t        sel_o
);
    // Scan from lowest priority to highest so the lowest index wins.
    always_comb begin
        sel_o.hit  = 1'b0;
        sel_o.code = CODE_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                sel_o.hit  = 1'b1;
                sel_o.code = src_code(i, NSRC);
            end
        end
    end

endmodule

// File: rtl/tmr_clr_decode.sv
module tmr_clr_decode
    import tmr_irq_pkg::*;
#(
    parameter int NSRC = 5
) (
    input  logic              rd_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [NSRC-1:0]   clr_o
);
    // Code 0 matches no source, so an empty read clears nothing.
    for (genvar g = 0; g < NSRC; g++) begin : g_dec
        assign clr_o[g] = rd_i && (code_i == src_code(g, NSRC));
    end

    assert_clr_onehot_R7: assert final ($onehot0(clr_o))
        else $error("more than one flag cleared by one read");

endmodule

// File: rtl/timer_irq_vector.sv
module timer_irq_vector
    import tmr_irq_pkg::*;
#(
    parameter int NUM_SHARED = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ch0_set,
    input  logic                  ch0_en,
    input  logic                  ch0_ack,
    input  logic [NUM_SHARED-1:0] shr_set,
    input  logic [NUM_SHARED-1:0] shr_en,
    input  logic                  ovf_set,
    input  logic                  ovf_en,
    input  logic                  vec_rd,
    output logic                  ch0_irq,
    output logic                  shr_irq,
    output logic [3:0]            vec_code
);
    localparam int NSRC = NUM_SHARED + 1;

    if (NUM_SHARED < 1 || NUM_SHARED > MAX_SHARED) begin : g_bad_cfg
        $error("NUM_SHARED out of range");
    end

    // ---------------- channel 0: private line ----------------
    logic ch0_flag_q, ch0_flag_d, ch0_pend, ch0_pend_d;

    tmr_flag_cell u_ch0 (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ch0_set),
        .clr_i  (ch0_ack),
        .en_i   (ch0_en),
        .flag_q (ch0_flag_q),
        .flag_d (ch0_flag_d),
        .pend_o (ch0_pend),
        .pend_d (ch0_pend_d)
    );

    assign ch0_irq = ch0_pend;

    // ---------------- shared sources ----------------
    logic [NSRC-1:0] src_set, src_en, src_clr;
    logic [NSRC-1:0] flag_q, flag_d, pend, pend_d;

    assign src_set = {ovf_set, shr_set};
    assign src_en  = {ovf_en,  shr_en};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        tmr_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (src_set[g]),
            .clr_i  (src_clr[g]),
            .en_i   (src_en[g]),
            .flag_q (flag_q[g]),
            .flag_d (flag_d[g]),
            .pend_o (pend[g]),
            .pend_d (pend_d[g])
        );
    end

    assign shr_irq = |pend;

    // The vector register follows the flags as they stand after this edge.
    vec_sel_t sel_next;
    logic [CODE_W-1:0] vec_q;

    tmr_prio_enc #(.NSRC(NSRC)) u_enc (
        .pend_i (pend_d),
        .sel_o  (sel_next)
    );

    always_ff @(posedge clk) begin
        if (rst)
            vec_q <= CODE_NONE;
        else
            vec_q <= sel_next.hit ? sel_next.code : CODE_NONE;
    end

    assign vec_code = vec_q;

    // A read clears the source named by the value the reader sees.
    tmr_clr_decode #(.NSRC(NSRC)) u_dec (
        .rd_i   (vec_rd),
        .code_i (vec_q),
        .clr_o  (src_clr)
    );

    // ---------------- assertions ----------------
    assert_vec_even_R5: assert property (@(posedge clk) disable iff (rst)
        vec_code[0] == 1'b0)
        else $error("odd vector code");

    assert_vec_legal_R5: assert property (@(posedge clk) disable iff (rst)
        (vec_code == CODE_OVF) || (int'(vec_code) <= 2 * NUM_SHARED))
        else $error("vector code names no source");

    assert_ch0_ack_R2: assert property (@(posedge clk) disable iff (rst)
        (ch0_ack && !ch0_set) |=> !ch0_irq)
        else $error("channel 0 request survived acknowledge");

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (vec_code == CODE_NONE && !ch0_irq && !shr_irq))
        else $error("outputs not cleared by reset");

endmodule

// File: tb/timer_irq_vector_bench.sv
module timer_irq_vector_bench;
    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ch0_set = 0, ch0_en = 0, ch0_ack = 0;
    logic [NS-1:0] shr_set = '0, shr_en = '0;
    logic ovf_set = 0, ovf_en = 0, vec_rd = 0;
    logic ch0_irq, shr_irq;
    logic [3:0] vec_code;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    timer_irq_vector #(.NUM_SHARED(NS)) u_timer_irq_vector (
        .clk(clk), .rst(rst),
        .ch0_set(ch0_set), .ch0_en(ch0_en), .ch0_ack(ch0_ack),
        .shr_set(shr_set), .shr_en(shr_en),
        .ovf_set(ovf_set), .ovf_en(ovf_en),
        .vec_rd(vec_rd),
        .ch0_irq(ch0_irq), .shr_irq(shr_irq), .vec_code(vec_code)
    );

    // ---------------- behavioural reference ----------------
    bit m_ch0;
    bit m_flag[NS+1];   // 0..NS-1 channels 1..NS, NS is overflow
    int m_vec;

    function automatic bit src_on(int i);
        if (i == NS) return ovf_en;
        return shr_en[i];
    endfunction

    function automatic bit src_hit(int i);
        if (i == NS) return ovf_set;
        return shr_set[i];
    endfunction

    always @(posedge clk) begin
        int victim;
        if (rst) begin
            m_ch0 = 0;
            foreach (m_flag[i]) m_flag[i] = 0;
            m_vec = 0;
        end else begin
            m_ch0 = ch0_set || (m_ch0 && !ch0_ack);
            victim = -1;
            if (vec_rd && m_vec != 0) victim = (m_vec == 14) ? NS : m_vec / 2 - 1;
            foreach (m_flag[i]) m_flag[i] = src_hit(i) || (m_flag[i] && victim != i);
            m_vec = 0;
            for (int i = NS; i >= 0; i--)
                if (m_flag[i] && src_on(i)) m_vec = (i == NS) ? 14 : 2 * (i + 1);
        end
    end

    function automatic bit m_shr();
        for (int i = 0; i <= NS; i++) if (m_flag[i] && src_on(i)) return 1;
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare against model every cycle, 1 ns after the edge.
    task automatic cmp_model();
        check("R1 ch0_irq vs model", ch0_irq, int'(m_ch0 && ch0_en));
        check("R3 shr_irq vs model", shr_irq, int'(m_shr()));
        check("R11 vec_code vs model", vec_code, m_vec);
    endtask

    // Drive at negedge, let one edge pass, then compare.
    task automatic step();
        @(posedge clk);
        #1;
        cmp_model();
        @(negedge clk);
        ch0_set = 0; ch0_ack = 0; shr_set = '0; ovf_set = 0; vec_rd = 0;
    endtask

    task automatic expect_out(string tag, int ev, int es, int ec);
        check({tag, " vec_code"}, vec_code, ev);
        check({tag, " shr_irq"},  shr_irq,  es);
        check({tag, " ch0_irq"},  ch0_irq,  ec);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        step(); step();
        @(negedge clk); rst = 0;
        expect_out("R10 after reset", 0, 0, 0);
        shr_en = '1; ovf_en = 1; ch0_en = 1;

        // R5/R11: channel 3 -> code 6 after one edge
        shr_set[2] = 1; step();
        expect_out("R5 ch3 code", 6, 1, 0);
        // R7: read clears it
        vec_rd = 1; step();
        expect_out("R7 read clears", 0, 0, 0);

        // R6: channel 1 and overflow together
        shr_set[0] = 1; ovf_set = 1; step();
        expect_out("R6 ch1 over ovf", 2, 1, 0);
        vec_rd = 1; step();
        expect_out("R7 other source remains", 14, 1, 0);
        vec_rd = 1; step();
        expect_out("R7 drained", 0, 0, 0);

        // R7: unread flag keeps requesting
        shr_set[1] = 1; step();
        for (int i = 0; i < 5; i++) step();
        expect_out("R7 unread persists", 4, 1, 0);
        vec_rd = 1; step();

        // R8: disabled channel 4 latches silently
        shr_en[3] = 0; shr_set[3] = 1; step();
        expect_out("R8 disabled hidden", 0, 0, 0);
        shr_en[3] = 1; step();
        expect_out("R8 enabled reported", 8, 1, 0);
        vec_rd = 1; step();
        expect_out("R4 empty vector", 0, 0, 0);

        // R9: set wins over read clear
        shr_set[0] = 1; step();
        vec_rd = 1; shr_set[0] = 1; step();
        expect_out("R9 set beats clear", 2, 1, 0);
        vec_rd = 1; step();

        // R1/R2: channel 0 private line
        ch0_set = 1; step();
        expect_out("R1 ch0 private", 0, 0, 1);
        ch0_ack = 1; step();
        expect_out("R2 ack clears", 0, 0, 0);
        ch0_set = 1; step();
        ch0_set = 1; ch0_ack = 1; step();
        expect_out("R2 set beats ack", 0, 0, 1);
        ch0_ack = 1; step();

        // Random phase, model compare every cycle
        for (int c = 0; c < 3000; c++) begin
            ch0_set = ($urandom % 8) == 0;
            ch0_ack = ($urandom % 4) == 0;
            ch0_en  = ($urandom % 16) != 0;
            shr_set = NS'($urandom) & NS'($urandom);
            ovf_set = ($urandom % 6) == 0;
            if ($urandom % 10 == 0) shr_en = NS'($urandom);
            if ($urandom % 10 == 0) ovf_en = 1'($urandom);
            vec_rd  = ($urandom % 3) == 0;
            rst     = ($urandom % 500) == 0;
            step();
            rst = 0;
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule